// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host reach a 32K x 8 asynchronous static RAM. The host raises a request with a direction bit, an address and write data. The controller then runs the memory's active-low chip select, output enable and write enable through a fixed sequence. When the access ends, it returns read data and pulses a completion flag.

The data side is split into three parts: an outgoing byte, an enable for the external tri-state driver, and an incoming byte. All phase lengths are parameters counted in clock cycles: read wait, turnaround, write setup and write pulse. With a 100 MHz clock the defaults (3, 1, 1, 2) cover the fastest memory grade with margin. That grade needs 12 ns access, a 10 ns write pulse, 7 ns data setup and up to 7 ns for the memory to release the bus.

A read holds chip select and output enable low for the read wait. The read byte is registered on the last edge of that wait. Strobes then go high for the turnaround count before the controller takes a new request. A write keeps chip select low throughout, in this order:
- turnaround cycles with both output enable and the driver off;
- setup cycles with the driver on;
- the write-enable pulse;
- one hold cycle that keeps address and data steady.

Top module: `sram_ctl`

## Requirements
- R1: In reset and when idle, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, ready is 1, done is 0, and rd_data resets to 0.
- R2: A request (req=1 while ready=1, req_wr=0 meaning read) is taken at that clock edge. For the next RD_WAIT cycles mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0. rd_data takes mem_dq_in on the edge ending the last of those cycles.
- R3: After a read, all strobes are 1 and mem_dq_oe is 0 for TURN cycles (TURN at least 1) with ready=0. Only then is ready 1 again.
- R4: A write request (req_wr=1) keeps mem_ce_n=0 for TURN+WR_SETUP+WR_PULSE+1 cycles, with mem_oe_n=1 throughout. mem_dq_oe is 0 in the first TURN cycles and 1 afterwards. mem_we_n is 0 only in the WR_PULSE cycles that follow the WR_SETUP cycles. The next cycle is idle.
- R5: During a write, mem_addr equals the accepted req_addr and mem_dq_out equals the accepted req_wdata. The memory therefore stores req_wdata at req_addr.
- R6: mem_dq_oe is never 1 while mem_oe_n is 0, nor in the cycle right after mem_oe_n was 0.
- R7: While mem_ce_n stays 0, mem_addr and mem_dq_out do not change.
- R8: A request presented while ready=0 is ignored. It starts no access and alters no memory word.
- R9: done is 1 for exactly one cycle per access. For a read this is the first turnaround cycle. For a write it is the hold cycle.
- R10: rd_data changes only on a read capture. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken when ready is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (15) | Word address |
| req_wdata | input | DW (8) | Byte to write |
| rd_data | output | DW (8) | Last byte read |
| ready | output | 1 | Idle, able to take a request |
| done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW (15) | Memory address |
| mem_dq_out | output | DW (8) | Byte toward the memory |
| mem_dq_oe | output | 1 | Enable for the external data driver |
| mem_dq_in | input | DW (8) | Byte from the memory |

## Verification
The assertions guard the bus rules on every cycle:
- the driver is never on together with output enable, or in the cycle after it;
- write enable appears only under chip select with the driver on;
- address and outgoing data hold steady under chip select;
- done is a single-cycle pulse;
- rd_data changes only at a completion;
- an access starts only from a request;
- idle outputs are quiet.

Only the bench scenarios can show the exact phase lengths of reads and writes, that data lands at the right address, and that returned bytes match. They can also show that requests raised while busy leave memory untouched. An exhaustive write/read sweep over a 64-word configuration against a behavioural memory model covers these.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_RREL   = 3'd2,
    ST_WTURN  = 3'd3,
    ST_WSET   = 3'd4,
    ST_WPULSE = 3'd5,
    ST_WHOLD  = 3'd6
  } st_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drv;
  } pins_t;

  // Memory-side pin levels for each phase
  function automatic pins_t pins_of(st_t s);
    pins_t p;
    p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    case (s)
      ST_RD:     begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      ST_WTURN:  p.ce_n = 1'b0;
      ST_WSET,
      ST_WHOLD:  begin p.ce_n = 1'b0; p.drv = 1'b1; end
      ST_WPULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
      default:   ;
    endcase
    return p;
  endfunction

  // Number of cycles spent in a phase
  function automatic int stay_cycles(st_t s, int rd, int trn, int setc, int pul);
    case (s)
      ST_RD:     return rd;
      ST_RREL:   return trn;
      ST_WTURN:  return trn;
      ST_WSET:   return setc;
      ST_WPULSE: return pul;
      default:   return 1;
    endcase
  endfunction

  // Counter preload for a phase lasting the given number of cycles
  function automatic int to_load(int cycles);
    return (cycles > 1) ? cycles - 1 : 0;
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_WAIT  = 3,
  parameter int TURN     = 1,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 2,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic          expired,
  output st_t           st_next,
  output logic          ready,
  output logic          done,
  output logic          accept,
  output logic          capture,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  st_t  st_q, st_d;
  logic done_q;

  assign ready   = (st_q == ST_IDLE);
  assign accept  = ready && req;
  assign capture = (st_q == ST_RD) && expired;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (req) st_d = req_wr ? ST_WTURN : ST_RD;
      ST_RD:     if (expired) st_d = ST_RREL;
      ST_RREL:   if (expired) st_d = ST_IDLE;
      ST_WTURN:  if (expired) st_d = ST_WSET;
      ST_WSET:   if (expired) st_d = ST_WPULSE;
      ST_WPULSE: if (expired) st_d = ST_WHOLD;
      ST_WHOLD:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign st_next  = st_d;
  assign tmr_load = (st_d != st_q);
  assign tmr_val  = CW'(to_load(stay_cycles(st_d, RD_WAIT, TURN, WR_SETUP, WR_PULSE)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= ((st_q == ST_RD) && (st_d == ST_RREL)) ||
                ((st_q == ST_WPULSE) && (st_d == ST_WHOLD));
    end
  end

  assign done = done_q;

  // R9: completion is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: leaving idle always stems from a request seen while idle
  p_start_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(req));

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rd_data <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int RD_WAIT  = 3,
  parameter int TURN     = 1,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          ready,
  output logic          done,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int MAXC = max4(RD_WAIT, TURN, WR_SETUP, WR_PULSE);
  localparam int CW   = $clog2(MAXC + 1) + 1;

  st_t           st_next;
  logic          accept, capture, tmr_load, expired;
  logic [CW-1:0] tmr_val;
  pins_t         pins_q;

  sram_ctl_seq #(
    .RD_WAIT(RD_WAIT), .TURN(TURN), .WR_SETUP(WR_SETUP),
    .WR_PULSE(WR_PULSE), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .expired(expired), .st_next(st_next), .ready(ready), .done(done),
    .accept(accept), .capture(capture), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sram_ctl_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(expired)
  );

  sram_ctl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rd_data(rd_data)
  );

  // Strobes registered from the next phase: glitch-free and aligned to the state
  always_ff @(posedge clk) begin
    if (!rst_n) pins_q <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    else        pins_q <= pins_of(st_next);
  end

  assign mem_ce_n  = pins_q.ce_n;
  assign mem_oe_n  = pins_q.oe_n;
  assign mem_we_n  = pins_q.we_n;
  assign mem_dq_oe = pins_q.drv;

  // R1: idle means quiet pins
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R6: never drive together with the memory's output enable
  p_no_contend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R6: one release cycle after output enable before driving
  p_release_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_oe_n) |-> !mem_dq_oe);

  // R4: write strobe only under chip select with data driven
  p_we_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

  // R7: address and outgoing data steady under chip select
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R10: read byte changes only alongside a completion
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);

endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int RW = 3;
  localparam int TN = 2;
  localparam int SU = 1;
  localparam int PU = 2;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;
  logic          ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] model [NW];
  logic [DW-1:0] expect_mem [NW];
  logic [DW-1:0] last_rd = '0;
  logic          prev_we_low = 1'b0;

  always #5 clk = ~clk;

  sram_ctl #(.AW(AW), .DW(DW), .RD_WAIT(RW), .TURN(TN), .WR_SETUP(SU), .WR_PULSE(PU)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .ready(ready), .done(done),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Behavioural memory: drives only during a read, stores on the end of a write strobe
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model[mem_addr] : 8'hEE;

  always @(negedge clk) begin
    if (prev_we_low && mem_we_n && !mem_ce_n) model[mem_addr] <= mem_dq_out;
    prev_we_low <= !mem_we_n;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(int a, int pass);
    return DW'((a * 29 + 7 + pass * 101) & 8'hFF);
  endfunction

  // One access with per-cycle checks; optional request poke while busy (R8)
  task automatic access(input bit wr, input int a, input int d, input bit poke);
    int total, cnt;
    total = wr ? (TN + SU + PU + 1) : (RW + TN);
    @(negedge clk);
    cnt = 0;
    while (!ready && cnt < 50) begin @(negedge clk); cnt++; end
    req = 1'b1; req_wr = wr; req_addr = AW'(a); req_wdata = DW'(d);
    @(negedge clk);
    req = 1'b0;
    for (int k = 1; k <= total + 1; k++) begin
      int e_ce, e_oe, e_we, e_doe, e_rdy, e_dn;
      e_ce = 1; e_oe = 1; e_we = 1; e_doe = 0; e_rdy = 0; e_dn = 0;
      if (k == total + 1) e_rdy = 1;
      else if (!wr) begin
        if (k <= RW) begin e_ce = 0; e_oe = 0; end
        e_dn = (k == RW + 1) ? 1 : 0;
      end else begin
        e_ce = 0;
        if (k > TN) e_doe = 1;
        if (k > TN + SU && k <= TN + SU + PU) e_we = 0;
        e_dn = (k == total) ? 1 : 0;
      end
      chk(mem_ce_n == e_ce[0], wr ? "R4" : "R2", $sformatf("ce_n k=%0d", k), mem_ce_n, e_ce);
      chk(mem_oe_n == e_oe[0], wr ? "R4" : "R2", $sformatf("oe_n k=%0d", k), mem_oe_n, e_oe);
      chk(mem_we_n == e_we[0], "R4", $sformatf("we_n k=%0d", k), mem_we_n, e_we);
      chk(mem_dq_oe == e_doe[0], "R6", $sformatf("dq_oe k=%0d", k), mem_dq_oe, e_doe);
      chk(ready == e_rdy[0], "R3", $sformatf("ready k=%0d", k), ready, e_rdy);
      chk(done == e_dn[0], "R9", $sformatf("done k=%0d", k), done, e_dn);
      if (!mem_ce_n) begin
        chk(mem_addr == AW'(a), "R7", "mem_addr", mem_addr, a);
        if (wr) chk(mem_dq_out == DW'(d), "R5", "mem_dq_out", mem_dq_out, d);
      end
      if (!wr && k == RW + 1) begin
        chk(rd_data == expect_mem[a], "R2", $sformatf("rd_data @%0d", a), rd_data, expect_mem[a]);
        last_rd = rd_data;
      end
      if (wr && k == total + 1)
        chk(rd_data == last_rd, "R10", "rd_data after write", rd_data, last_rd);
      if (poke && k == 2) begin
        req = 1'b1; req_wr = 1'b1; req_addr = AW'(a ^ 1); req_wdata = ~DW'(d);
      end
      if (poke && k == 3) req = 1'b0;
      if (k <= total) @(negedge clk);
    end
    if (wr) expect_mem[a] = DW'(d);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin model[i] = 8'h00; expect_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe, "R1", "dq_oe in reset", mem_dq_oe, 0);
    chk(!done, "R1", "done in reset", done, 0);
    chk(rd_data == '0, "R1", "rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready, "R1", "ready after reset", ready, 1);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "idle pins", mem_dq_oe, 0);

    // R5: fill every word
    for (int a = 0; a < NW; a++) access(1'b1, a, pattern(a, 0), 1'b0);
    // R2/R8: read back every word, poking a write request while busy on some
    for (int a = 0; a < NW; a++) access(1'b0, a, 0, (a % 4) == 0);
    // R3/R10: back-to-back read/write mixes with fresh values
    for (int a = 0; a < 16; a++) begin
      access(1'b0, a, 0, 1'b0);
      access(1'b1, a, pattern(a, 1), (a % 3) == 0);
      access(1'b0, a, 0, 1'b0);
    end
    // R8: final sweep shows no stray writes from ignored requests
    for (int a = 0; a < NW; a++) access(1'b0, a, 0, 1'b0);
    for (int a = 0; a < NW; a++)
      chk(model[a] == expect_mem[a], "R8", $sformatf("word %0d", a), model[a], expect_mem[a]);
    summary();
  end

endmodule